// File: doc/BRIEF.md
# Video Timing Interrupt Controller

This block merges video-timing happenings into one interrupt line for a host processor. A periodic timing event is taken from exactly one of three sources picked by a select field: the rising edge of an asynchronous vertical-sync input, the moment a line counter reaches a programmed line number, or a tick from a programmable prescaler sized so that it fires every 10 ms at the system clock. Three more status conditions come from external detectors as single-cycle pulses: loss of sync, a clock-tracking error past its limit, and a horizontal or vertical timing shift past its limit. The two limits are kept here as registers and driven out to those detectors.

Every condition sets a sticky status bit. Each bit has an enable, and the interrupt is active while any enabled bit is set. A status read clears only the bits that were set when the read happened. After every read the interrupt goes inactive for at least one clock. If an event arrives during the read, the interrupt then comes back. The level of the active output is programmable.

The register port is write-only: wr_addr 0 holds the control word, 1 the target line, 2 the prescaler divide value and 3 the two limits. The status is always visible on stat_o, and the stat_rd strobe marks a read.

Top module: `vtm_irq_ctrl`

## Requirements
- R1: Control word bits [1:0] pick the timing source (0 vertical sync, 1 line match, 2 prescaler tick, 3 none). Only the picked source sets status bit 0. Events from the other sources have no effect on it.
- R2: A rising edge on vsync_in passes through a two-flop synchronizer. It sets status bit 0 on the third clock edge after the input rises. A level held high, and a falling edge, cause no further event.
- R3: A frame_start pulse clears the line counter and each line_tick adds one. Status bit 0 is set on the edge of the line_tick that brings the count to the target held at address 1.
- R4: With a divide value N≠0 at address 2, the prescaler fires once every N clocks. With N=0 it never fires.
- R5: A one-cycle pulse on sync_lost, track_err or geom_chg sets status bit 1, 2 or 3 on the next edge. This happens whatever the select field holds.
- R6: Status bits stay set until read. A stat_rd pulse clears the bits that were set at that edge. An event in the same cycle leaves its bit set.
- R7: The internal interrupt becomes active one clock after an enabled status bit is set. Enables are control bits [5:2], one per status bit 0..3. Disabled bits never activate it.
- R8: In the clock after a stat_rd pulse the interrupt is inactive. It becomes active again in the following clock if an enabled bit is still set.
- R9: Control bit 6 picks the level of irq_o: 1 drives the active interrupt high, 0 drives it low.
- R10: A status read changes neither the threshold outputs nor the line counter. Address 3 drives thr_track from bits [7:0] and thr_geom from bits [15:8].
- R11: After reset the status is zero, all enables are off, the polarity is active-low (irq_o high) and the thresholds are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 32 | Write data |
| stat_rd | input | 1 | Status read strobe, clears the bits read |
| stat_o | output | 4 | Sticky status: bit0 timing, bit1 sync loss, bit2 tracking, bit3 geometry |
| vsync_in | input | 1 | Asynchronous vertical sync |
| frame_start | input | 1 | Clears the line counter |
| line_tick | input | 1 | One pulse per panel line |
| sync_lost | input | 1 | Sync-loss detector pulse |
| track_err | input | 1 | Tracking-error detector pulse |
| geom_chg | input | 1 | Timing-change detector pulse |
| thr_track | output | 8 | Tracking-error limit |
| thr_geom | output | 8 | Timing-change limit |
| irq_o | output | 1 | Interrupt, level set by polarity |

## Verification
The hardest case to reach is an event that lands in the same clock as a status read. The stimulus first sets one status bit and waits for the interrupt. It then drives stat_rd and a different detector pulse in one cycle. The bench expects the old bit to be cleared, the new bit to remain, the interrupt to drop for one clock and then come back. The prescaler's phase at the start is unknown, so the bench synchronizes to its first tick and measures the spacing to the next one.

// File: rtl/vtm_irq_pkg.sv
// Shared types and field positions for the video timing interrupt controller.
// Assumes a 4-bit status vector: bit0 timing, bit1 sync loss, bit2 tracking, bit3 geometry.
package vtm_irq_pkg;
    typedef enum logic [1:0] {
        SRC_VSYNC = 2'd0,
        SRC_LINE  = 2'd1,
        SRC_TICK  = 2'd2,
        SRC_NONE  = 2'd3
    } tsrc_e;

    localparam int NUM_STAT  = 4;
    localparam int ST_TIMING = 0;
    localparam int ST_SYNC   = 1;
    localparam int ST_TRACK  = 2;
    localparam int ST_GEOM   = 3;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_LINE = 2'd1;
    localparam logic [1:0] A_DIV  = 2'd2;
    localparam logic [1:0] A_THR  = 2'd3;

    localparam int C_EN_LSB = 2;
    localparam int C_POL    = 6;
endpackage

// File: rtl/vtm_vsync_edge.sv
// Brings the asynchronous vertical sync into the clock domain with two flops
// and gives a one-cycle pulse on each rising edge. Assumes vsync is low in reset.
module vtm_vsync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_in,
    output logic rise
);
    logic s1, s2, s3;

    // synchronizer chain plus history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= vsync_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/vtm_line_match.sv
// Counts panel lines since the last frame start and flags the line whose
// tick brings the count to the target. frame_start wins over a same-cycle tick.
module vtm_line_match #(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_tick,
    input  logic [LINE_W-1:0] target,
    output logic              hit
);
    logic [LINE_W-1:0] cnt;
    logic [LINE_W-1:0] cnt_nxt;

    assign cnt_nxt = cnt + 1'b1;
    assign hit     = line_tick && !frame_start && (cnt_nxt == target);

    // line counter: cleared at frame start, advanced by each line tick
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (frame_start) cnt <= '0;
        else if (line_tick)   cnt <= cnt_nxt;
    end

    // R3
    frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (cnt == '0));
endmodule

// File: rtl/vtm_tick_gen.sv
// Prescaler giving a one-cycle tick every div clocks; div = 0 stops ticks.
// Assumes software sets div to the clock rate times 10 ms.
module vtm_tick_gen #(
    parameter int DIV_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (div != '0) && (cnt >= div - 1'b1);

    // free-running divide counter, wraps on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div != '0) |=> (cnt < $past(div)));
endmodule

// File: rtl/vtm_irq_ctrl.sv
// Video timing interrupt controller: config registers, source select, sticky
// status with read-to-clear, enable masking and output polarity.
// Assumes detector inputs are synchronous single-cycle pulses.
module vtm_irq_ctrl
    import vtm_irq_pkg::*;
#(
    parameter int LINE_W = 12,
    parameter int DIV_W  = 24,
    parameter int THR_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                stat_rd,
    output logic [NUM_STAT-1:0] stat_o,
    input  logic                vsync_in,
    input  logic                frame_start,
    input  logic                line_tick,
    input  logic                sync_lost,
    input  logic                track_err,
    input  logic                geom_chg,
    output logic [THR_W-1:0]    thr_track,
    output logic [THR_W-1:0]    thr_geom,
    output logic                irq_o
);
    tsrc_e               src_sel;
    logic [NUM_STAT-1:0] en_mask;
    logic                pol_hi;
    logic [LINE_W-1:0]   line_target;
    logic [DIV_W-1:0]    div_val;
    logic [2*THR_W-1:0]  thr_reg;

    logic                vs_rise, line_hit, tick;
    logic                tevt;
    logic [NUM_STAT-1:0] evt;
    logic [NUM_STAT-1:0] status;
    logic                irq_q;

    // configuration register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel     <= SRC_VSYNC;
            en_mask     <= '0;
            pol_hi      <= 1'b0;
            line_target <= '0;
            div_val     <= '0;
            thr_reg     <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    src_sel <= tsrc_e'(wr_data[1:0]);
                    en_mask <= wr_data[C_EN_LSB +: NUM_STAT];
                    pol_hi  <= wr_data[C_POL];
                end
                A_LINE:  line_target <= wr_data[LINE_W-1:0];
                A_DIV:   div_val     <= wr_data[DIV_W-1:0];
                default: thr_reg     <= wr_data[2*THR_W-1:0];
            endcase
        end
    end

    assign thr_track = thr_reg[THR_W-1:0];
    assign thr_geom  = thr_reg[2*THR_W-1:THR_W];

    vtm_vsync_edge u_vs (
        .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .rise(vs_rise)
    );

    vtm_line_match #(.LINE_W(LINE_W)) u_line (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_tick(line_tick), .target(line_target), .hit(line_hit)
    );

    vtm_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(div_val), .tick(tick)
    );

    // pick the single periodic timing source
    always_comb begin
        case (src_sel)
            SRC_VSYNC: tevt = vs_rise;
            SRC_LINE:  tevt = line_hit;
            SRC_TICK:  tevt = tick;
            default:   tevt = 1'b0;
        endcase
    end

    assign evt = {geom_chg, track_err, sync_lost, tevt};

    // sticky status: a read clears what was set, same-cycle events survive
    always_ff @(posedge clk) begin
        if (!rst_n)       status <= '0;
        else if (stat_rd) status <= evt;
        else              status <= status | evt;
    end

    // interrupt state, forced inactive for the cycle after a read
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_q <= 1'b0;
        else if (stat_rd) irq_q <= 1'b0;
        else              irq_q <= |(status & en_mask);
    end

    assign stat_o = status;
    assign irq_o  = pol_hi ? irq_q : ~irq_q;

    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((status & $past(status)) == $past(status)));

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && (evt == '0)) |=> (status == '0));

    // R7
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rd && |(status & en_mask)) |=> irq_q);

    // R7
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status & en_mask)) |=> !irq_q);

    // R8
    read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !irq_q);
endmodule

// File: tb/vtm_irq_ctrl_test.sv
module vtm_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        stat_rd = 1'b0;
    logic [3:0]  stat_o;
    logic        vsync_in = 1'b0, frame_start = 1'b0, line_tick = 1'b0;
    logic        sync_lost = 1'b0, track_err = 1'b0, geom_chg = 1'b0;
    logic [7:0]  thr_track, thr_geom;
    logic        irq_o;
    int          n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    vtm_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .stat_rd(stat_rd), .stat_o(stat_o),
        .vsync_in(vsync_in), .frame_start(frame_start), .line_tick(line_tick),
        .sync_lost(sync_lost), .track_err(track_err), .geom_chg(geom_chg),
        .thr_track(thr_track), .thr_geom(thr_geom), .irq_o(irq_o)
    );

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd();
        stat_rd = 1'b1;
        step();
        stat_rd = 1'b0;
    endtask

    // control word: src | enables<<2 | pol<<6
    function automatic logic [31:0] ctl(logic [1:0] s, logic [3:0] e, logic p);
        return {25'd0, p, e, s};
    endfunction

    task automatic t_reset();
        chk("R11 status", stat_o, 4'h0);
        chk("R11 irq inactive high", irq_o, 1'b1);
        chk("R11 thr_track", thr_track, 8'h00);
        chk("R11 thr_geom", thr_geom, 8'h00);
    endtask

    task automatic t_detectors();
        wr(2'd0, ctl(2'd3, 4'b0010, 1'b1));
        track_err = 1'b1; step(); track_err = 1'b0;
        chk("R5 track bit", stat_o, 4'b0100);
        step();
        chk("R7 masked bit no irq", irq_o, 1'b0);
        sync_lost = 1'b1; step(); sync_lost = 1'b0;
        chk("R5 sync bit", stat_o, 4'b0110);
        chk("R7 irq not yet", irq_o, 1'b0);
        step();
        chk("R7 irq active", irq_o, 1'b1);
        step(5);
        chk("R6 sticky", stat_o, 4'b0110);
        rd();
        chk("R6 read clears", stat_o, 4'b0000);
        chk("R8 irq low after read", irq_o, 1'b0);
        step();
        chk("R8 stays low when clear", irq_o, 1'b0);
    endtask

    task automatic t_read_overlap();
        wr(2'd0, ctl(2'd3, 4'b1111, 1'b1));
        geom_chg = 1'b1; step(); geom_chg = 1'b0;
        step();
        chk("R7 geom irq", irq_o, 1'b1);
        stat_rd = 1'b1; sync_lost = 1'b1;
        step();
        stat_rd = 1'b0; sync_lost = 1'b0;
        chk("R6 overlap keeps new bit", stat_o, 4'b0010);
        chk("R8 gap during overlap", irq_o, 1'b0);
        step();
        chk("R8 reassert", irq_o, 1'b1);
        rd();
        step();
        chk("R8 quiet after final read", irq_o, 1'b0);
    endtask

    task automatic t_polarity();
        wr(2'd0, ctl(2'd3, 4'b0100, 1'b0));
        chk("R9 inactive low-pol", irq_o, 1'b1);
        track_err = 1'b1; step(); track_err = 1'b0;
        step();
        chk("R9 active low-pol", irq_o, 1'b0);
        rd();
        step();
        chk("R9 back inactive", irq_o, 1'b1);
    endtask

    task automatic t_vsync();
        wr(2'd0, ctl(2'd0, 4'b0001, 1'b1));
        rd();
        vsync_in = 1'b1;
        step(2);
        chk("R2 not before sync delay", stat_o[0], 1'b0);
        step();
        chk("R2 edge seen", stat_o[0], 1'b1);
        rd();
        step(8);
        chk("R2 held level no event", stat_o[0], 1'b0);
        vsync_in = 1'b0;
        step(6);
        chk("R2 falling edge ignored", stat_o[0], 1'b0);
    endtask

    task automatic t_line();
        wr(2'd1, 32'd3);
        wr(2'd0, ctl(2'd1, 4'b0001, 1'b1));
        wr(2'd3, 32'h0000_AB12);
        rd();
        frame_start = 1'b1; step(); frame_start = 1'b0;
        for (int i = 0; i < 2; i++) begin
            line_tick = 1'b1; step(); line_tick = 1'b0; step(2);
        end
        chk("R3 no hit before target", stat_o[0], 1'b0);
        line_tick = 1'b1; step(); line_tick = 1'b0;
        chk("R3 hit at target", stat_o[0], 1'b1);
        rd();
        line_tick = 1'b1; step(); line_tick = 1'b0;
        chk("R3 no hit past target", stat_o[0], 1'b0);
        // reads interleaved with lines must not disturb the count
        frame_start = 1'b1; step(); frame_start = 1'b0;
        for (int i = 0; i < 2; i++) begin
            line_tick = 1'b1; step(); line_tick = 1'b0;
            rd();
        end
        chk("R10 thr_track kept", thr_track, 8'h12);
        chk("R10 thr_geom kept", thr_geom, 8'hAB);
        line_tick = 1'b1; step(); line_tick = 1'b0;
        chk("R10 count kept across reads", stat_o[0], 1'b1);
        rd();
    endtask

    task automatic t_tick();
        int k;
        wr(2'd2, 32'd10);
        wr(2'd0, ctl(2'd2, 4'b0001, 1'b1));
        rd();
        k = 0;
        while (!stat_o[0] && k < 40) begin step(); k++; end
        chk("R4 first tick", stat_o[0], 1'b1);
        rd();
        k = 1;
        while (!stat_o[0] && k < 40) begin step(); k++; end
        chk("R4 tick spacing", k, 10);
        wr(2'd2, 32'd0);
        rd();
        // other sources active while tick selected and stopped
        wr(2'd1, 32'd1);
        frame_start = 1'b1; step(); frame_start = 1'b0;
        line_tick = 1'b1; step(); line_tick = 1'b0;
        vsync_in = 1'b1; step(5); vsync_in = 1'b0;
        step(30);
        chk("R1 unselected sources ignored", stat_o[0], 1'b0);
        chk("R4 div zero no tick", stat_o, 4'h0);
    endtask

    initial begin
        step(5);
        t_reset();
        rst_n = 1'b1;
        step();
        t_detectors();
        t_read_overlap();
        t_polarity();
        t_vsync();
        t_line();
        t_tick();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule